// File: doc/BRIEF.md
# Bus-Programmed Window Watchdog

This block is a supervisory watchdog that is armed, reconfigured and serviced by single command bytes handed over from a register interface as valid-strobed bytes. Each accepted byte picks time-out or window operation and a period code, clears the running count and starts a fresh period. If the period runs out, or if a window-mode command arrives too early, the block drives an active-low reset request for a fixed base length plus a programmable extension, then disarms itself. It stays disarmed until the next command byte.

All timing advances on a tick enable input rather than on every clock, so one instance can run from a slow timebase on chip and from a fast one in a bench. Period lengths come from a table built from parameters: entry `i` lasts `BASE_TICKS << i` ticks.

Top module: `bus_wdog`

## Requirements
- R1: After reset `rst_req_no` is 1 and `armed_o` is 0, and no reset request is made, however long, until a command byte is accepted.
- R2: Command byte encoding: bit 7 selects the mode (1 = window, 0 = time-out), bits 2:0 select period index `i` with a period of `BASE_TICKS << i` ticks (4, 8, ... 512 at defaults); bits 6:3 have no effect.
- R3: With no further command, `rst_req_no` falls on the edge carrying the period's last tick: sampled after each edge that follows the accepting edge, it is first 0 after exactly `period` ticks.
- R4: An accepted command restarts the count with its own mode and period; a command on the same edge as the final tick wins, so no reset request is made then.
- R5: The request lasts `RST_BASE + rst_ext_i` ticks (10 + ext at defaults), with `rst_ext_i` taken on the edge where the request starts; later changes have no effect on it.
- R6: When a request starts, `armed_o` goes to 0 and stays 0; no further request follows until a new command is accepted.
- R7: In window mode a command arriving while fewer than `period/2` ticks have elapsed is a violation: the request starts on that edge and the block disarms; a command at `period/2` ticks or later is accepted normally.
- R8: A command presented while `rst_req_no` is 0 is ignored: after the request ends the block is still disarmed.
- R9: The period count and the request length advance only on edges where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase enable, one tick per cycle it is high |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_byte_i | input | 8 | Command byte: mode bit 7, period index bits 2:0 |
| rst_ext_i | input | EXT_W | Reset request extension in ticks |
| rst_req_no | output | 1 | Active-low reset request |
| armed_o | output | 1 | Watchdog running |

## Verification
The two functions that can meet on one edge are servicing and expiry: a time-out command whose strobe lands on the edge of the final tick, where the command must win and restart the period. The bench provokes it by holding three idle edges after a period-4 command and strobing the next command on the fourth, then judges that the request stays high and a full new period of four ticks elapses before the request. The window boundary is treated alike, with commands placed one edge before and exactly on the half-period edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    MODE_TIMEOUT = 1'b0,
    MODE_WINDOW  = 1'b1
  } wd_mode_e;
endpackage

// File: rtl/wdog_cmd_dec.sv
module wdog_cmd_dec
  import wdog_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             mode_bit_i,
  input  logic [IDX_W-1:0] idx_bits_i,
  input  logic [IDX_W-1:0] unused_sel_i,
  output wd_mode_e         mode_o,
  output logic [IDX_W-1:0] idx_o
);
  wd_mode_e mode_d;
  logic unused_sel;

  assign unused_sel = ^unused_sel_i;

  always_comb begin
    mode_d = mode_bit_i ? MODE_WINDOW : MODE_TIMEOUT;
  end

  assign mode_o = mode_d;
  assign idx_o  = idx_bits_i;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             accept_i,
  input  wd_mode_e         mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             armed_o,
  output logic             fire_o
);
  logic             armed_q;
  wd_mode_e         mode_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;
  logic             too_early;
  logic             run_out;

  // early service in window mode only counts while armed
  assign too_early = accept_i && armed_q && (mode_q == MODE_WINDOW) &&
                     (cnt_q < (period_q >> 1));
  assign run_out   = armed_q && tick_i && !accept_i &&
                     (cnt_q == period_q - CNT_W'(1));
  assign fire_o    = too_early || run_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      mode_q   <= MODE_TIMEOUT;
      period_q <= '0;
      cnt_q    <= '0;
    end else if (fire_o) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (accept_i) begin
      armed_q  <= 1'b1;
      mode_q   <= mode_i;
      period_q <= period_i;
      cnt_q    <= '0;
    end else if (armed_q && tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int RST_BASE = 10,
  parameter int EXT_W    = 4,
  parameter int PULSE_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             fire_i,
  input  logic [EXT_W-1:0] ext_i,
  output logic             active_o
);
  logic [PULSE_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (fire_i) begin
      left_q <= PULSE_W'(RST_BASE) + PULSE_W'(ext_i);
    end else if (tick_i && (left_q != '0)) begin
      left_q <= left_q - PULSE_W'(1);
    end
  end

  assign active_o = (left_q != '0);
endmodule

// File: rtl/bus_wdog.sv
module bus_wdog
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 4,
  parameter int IDX_W      = 3,
  parameter int RST_BASE   = 10,
  parameter int EXT_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_byte_i,
  input  logic [EXT_W-1:0] rst_ext_i,
  output logic             rst_req_no,
  output logic             armed_o
);
  localparam int NUM_PER = 2 ** IDX_W;
  localparam int CNT_W   = $clog2(BASE_TICKS << (NUM_PER - 1)) + 1;
  localparam int PULSE_W = $clog2(RST_BASE + 2 ** EXT_W) + 1;

  logic [CNT_W-1:0] period_tbl [NUM_PER];
  wd_mode_e         cmd_mode;
  logic [IDX_W-1:0] cmd_idx;
  logic             pulse_on;
  logic             accept;
  logic             fire;

  for (genvar g = 0; g < NUM_PER; g++) begin : g_per
    assign period_tbl[g] = CNT_W'(BASE_TICKS << g);
  end

  wdog_cmd_dec #(.IDX_W(IDX_W)) u_dec (
    .mode_bit_i  (cmd_byte_i[7]),
    .idx_bits_i  (cmd_byte_i[IDX_W-1:0]),
    .unused_sel_i(cmd_byte_i[2*IDX_W-1:IDX_W]),
    .mode_o      (cmd_mode),
    .idx_o       (cmd_idx)
  );

  logic unused_hi;
  assign unused_hi = cmd_byte_i[6];

  // commands are dropped while a request is running
  assign accept = cmd_valid_i && !pulse_on;

  wdog_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .accept_i(accept),
    .mode_i  (cmd_mode),
    .period_i(period_tbl[cmd_idx]),
    .armed_o (armed_o),
    .fire_o  (fire)
  );

  wdog_pulse #(.RST_BASE(RST_BASE), .EXT_W(EXT_W), .PULSE_W(PULSE_W)) u_pls (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .fire_i  (fire),
    .ext_i   (rst_ext_i),
    .active_o(pulse_on)
  );

  assign rst_req_no = !pulse_on;
endmodule

// File: rtl/bus_wdog_chk.sv
module bus_wdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic cmd_valid_i,
  input logic rst_req_no,
  input logic armed_o
);
  // R3
  req_from_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_no) |-> $past(armed_o));
  // R6
  disarm_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed_o) |-> !rst_req_no);
  // R8
  cmd_in_req_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_no && cmd_valid_i) |=> !armed_o);
  // R9
  req_holds_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_no && !tick_i) |=> !rst_req_no);
  // R9
  armed_holds_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !tick_i && !cmd_valid_i) |=> (armed_o && rst_req_no));
  // R4
  arm_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && rst_req_no && !armed_o) |=> armed_o);
endmodule

bind bus_wdog bus_wdog_chk u_chk (.*);

// File: tb/bus_wdog_bench.sv
module bus_wdog_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       cmd_valid_i = 1'b0;
  logic [7:0] cmd_byte_i = 8'h00;
  logic [3:0] rst_ext_i = 4'd0;
  logic       rst_req_no;
  logic       armed_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  bus_wdog u_bus_wdog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cmd_valid_i(cmd_valid_i),
    .cmd_byte_i (cmd_byte_i),
    .rst_ext_i  (rst_ext_i),
    .rst_req_no (rst_req_no),
    .armed_o    (armed_o)
  );

  // {cmd, ext, expected period, expected request length}
  localparam logic [27:0] VEC [6] = '{
    {8'h00, 4'd0,  10'd4,   6'd10},
    {8'h01, 4'd3,  10'd8,   6'd13},
    {8'h82, 4'd5,  10'd16,  6'd15},
    {8'h7B, 4'd15, 10'd32,  6'd25},
    {8'h05, 4'd1,  10'd128, 6'd11},
    {8'h87, 4'd2,  10'd512, 6'd12}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    cmd_byte_i  = b;
    cmd_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      if (!rst_req_no) break;
    end
  endtask

  task automatic wait_rise(output int m);
    m = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk_i);
      m++;
      @(negedge clk_i);
      if (rst_req_no) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int n;
    int m;
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset rst_req_no", int'(rst_req_no), 1);
    check("R1 reset armed_o", int'(armed_o), 0);
    idle(600);
    check("R1 idle no request", int'(rst_req_no), 1);

    for (int v = 0; v < 6; v++) begin
      rst_ext_i = VEC[v][19:16];
      send_cmd(VEC[v][27:20]);
      wait_fall(n);
      check("R2 R3 period", n, int'(VEC[v][15:6]));
      check("R6 disarmed at request", int'(armed_o), 0);
      rst_ext_i = 4'd9;
      wait_rise(m);
      check("R5 request length", m, int'(VEC[v][5:0]));
    end
    rst_ext_i = 4'd0;
    idle(600);
    check("R6 no request after expiry", int'(rst_req_no), 1);
    check("R6 stays disarmed", int'(armed_o), 0);

    // window: command with 0 ticks elapsed
    send_cmd(8'h80);
    send_cmd(8'h80);
    check("R7 early service request", int'(rst_req_no), 0);
    check("R7 early service disarm", int'(armed_o), 0);
    // command during the request is ignored
    send_cmd(8'h00);
    wait_rise(m);
    check("R8 cmd in request ignored", int'(armed_o), 0);
    idle(50);
    check("R8 no later request", int'(rst_req_no), 1);

    // window: command with 1 tick elapsed
    send_cmd(8'h80);
    idle(1);
    send_cmd(8'h80);
    check("R7 service before half", int'(rst_req_no), 0);
    wait_rise(m);

    // window: command exactly at half period
    send_cmd(8'h80);
    idle(2);
    send_cmd(8'h80);
    check("R7 service at half", int'(rst_req_no), 1);
    check("R7 armed after half service", int'(armed_o), 1);
    wait_fall(n);
    check("R7 period after service", n, 4);
    wait_rise(m);

    // time-out: command on the final tick edge wins
    send_cmd(8'h00);
    idle(3);
    send_cmd(8'h00);
    check("R4 collision no request", int'(rst_req_no), 1);
    check("R4 collision armed", int'(armed_o), 1);
    wait_fall(n);
    check("R4 collision new period", n, 4);
    wait_rise(m);

    // reprogram mid-period to a shorter one
    send_cmd(8'h03);
    idle(10);
    send_cmd(8'h01);
    wait_fall(n);
    check("R4 reprogram period", n, 8);
    wait_rise(m);

    // tick gating of count and request
    send_cmd(8'h00);
    tick_i = 1'b0;
    idle(20);
    check("R9 count holds no tick", int'(rst_req_no), 1);
    tick_i = 1'b1;
    wait_fall(n);
    check("R9 period in ticks", n, 4);
    tick_i = 1'b0;
    idle(20);
    check("R9 request holds no tick", int'(rst_req_no), 0);
    tick_i = 1'b1;
    wait_rise(m);
    check("R9 request length in ticks", m, 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule